// File: doc/BRIEF.md
# Next-PC Select Unit

This block holds the program counter of a small 32-bit processor and works out the address of the next instruction. On each clock edge where the controller asserts the load strobe, the counter takes one of four candidate values. The candidate is chosen by the instruction class that the controller decodes: a plain increment by four, a jump that keeps the current 256 MiB region, a jump to a register value, or a conditional branch.

The branch condition comes from two flags that the block makes from the register operands it is given. One flag is an equality test of the two operands. The other is the sign of the first operand. Both flags are also driven out, so the controller can see them. Fetch, the register file and the arithmetic datapath stay outside; this unit only sees the operand values and the instruction fields.

Internally a comparator builds the flags, a target generator forms every candidate address in parallel, and a selector picks one of them by class and flag. The top module adds the counter register.

Top module: `npc_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads the counter with zero, whatever `ld_pc` and the class are.
- R2: Outside reset, when `ld_pc` is low at a rising edge the counter keeps its value, whatever the class and operands are.
- R3: Class code 0 (sequential) loads the counter with its current value plus 4.
- R4: Class code 1 (jump) loads the counter's own bits 31..28, then the 26-bit `jfield`, then two zero bits.
- R5: Class code 2 (register jump) loads the value on `rs_val`.
- R6: Class code 3 (branch if equal) loads the counter plus the sign-extended 16-bit `imm` when `rs_val` equals `rt_val`, and the counter plus 4 otherwise.
- R7: Class code 4 (branch if negative) loads the counter plus the sign-extended `imm` when bit 31 of `rs_val` is 1, and the counter plus 4 otherwise.
- R8: `eq_flag` is 1 exactly when all 32 bits of `rs_val` and `rt_val` match, and it follows the operands in the same cycle.
- R9: `neg_flag` equals bit 31 of `rs_val` in the same cycle.
- R10: The unused class codes 5, 6 and 7 act as code 0 and add 4.
- R11: All sums wrap modulo 2^32, so 32'hFFFF_FFFC plus 4 gives 0, and a negative offset from 0 gives a high address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_pc | input | 1 | Update strobe for the counter |
| cls | input | 3 | Instruction class code (0 seq, 1 jump, 2 register jump, 3 branch equal, 4 branch negative) |
| jfield | input | 26 | Jump address field |
| imm | input | 16 | Branch offset, two's complement |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| pc | output | 32 | Current program counter |
| eq_flag | output | 1 | Operands equal |
| neg_flag | output | 1 | First operand negative |

## Verification
The hardest states to reach are the ones that depend on the counter's own history. Examples are a jump whose region bits are not zero, an increment that wraps past the top of the address space, and a negative branch offset from address zero. None of these can be driven straight from the ports. The stimulus table therefore first uses register jumps to plant chosen values in the counter, such as 32'hA000_0010 and 32'hFFFF_FFFC, and then applies the instruction under test. The equality test is exercised with operands that differ only above bit 15, so a comparison that looks at only part of the word is exposed.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN   = 32;
    localparam int JF_W   = 26;
    localparam int IMM_W  = 16;
    localparam int CLS_W  = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_SEQ  = 3'd0,
        CLS_JUMP = 3'd1,
        CLS_JREG = 3'd2,
        CLS_BEQ  = 3'd3,
        CLS_BLTZ = 3'd4
    } flow_cls_t;

endpackage

// File: rtl/npc_cmp.sv
module npc_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         eq_o,
    output logic         neg_o
);
    // full-width equality and sign of first operand
    always_comb begin
        eq_o  = (a_i == b_i);
        neg_o = a_i[W-1];
    end
endmodule

// File: rtl/npc_targets.sv
module npc_targets #(
    parameter int W    = 32,
    parameter int JW   = 26,
    parameter int IW   = 16
) (
    input  logic [W-1:0]  pc_i,
    input  logic [JW-1:0] jf_i,
    input  logic [IW-1:0] imm_i,
    output logic [W-1:0]  seq_o,
    output logic [W-1:0]  jmp_o,
    output logic [W-1:0]  br_o
);
    localparam int REGW = W - JW - 2;
    localparam int EXTW = W - IW;

    logic [W-1:0] off_sx;

    always_comb begin
        off_sx = {{EXTW{imm_i[IW-1]}}, imm_i};
        seq_o  = pc_i + W'(4);
        br_o   = pc_i + off_sx;
    end

    generate
        if (REGW > 0) begin : g_region
            assign jmp_o = {pc_i[W-1 -: REGW], jf_i, 2'b00};
        end else begin : g_flat
            assign jmp_o = {jf_i[W-3:0], 2'b00};
        end
    endgenerate
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter int W = 32
) (
    input  flow_cls_t    cls_i,
    input  logic         eq_i,
    input  logic         neg_i,
    input  logic [W-1:0] seq_i,
    input  logic [W-1:0] jmp_i,
    input  logic [W-1:0] br_i,
    input  logic [W-1:0] reg_i,
    output logic [W-1:0] nxt_o
);
    always_comb begin
        unique case (cls_i)
            CLS_JUMP: nxt_o = jmp_i;
            CLS_JREG: nxt_o = reg_i;
            CLS_BEQ:  nxt_o = eq_i  ? br_i : seq_i;
            CLS_BLTZ: nxt_o = neg_i ? br_i : seq_i;
            default:  nxt_o = seq_i;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int JW = JF_W,
    parameter int IW = IMM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_pc,
    input  logic [CLS_W-1:0]  cls,
    input  logic [JW-1:0]     jfield,
    input  logic [IW-1:0]     imm,
    input  logic [W-1:0]      rs_val,
    input  logic [W-1:0]      rt_val,
    output logic [W-1:0]      pc,
    output logic              eq_flag,
    output logic              neg_flag
);
    logic [W-1:0] pc_q;
    logic [W-1:0] seq_t, jmp_t, br_t, nxt;
    flow_cls_t    cls_e;

    always_comb cls_e = flow_cls_t'(cls);

    npc_cmp #(.W(W)) u_cmp (
        .a_i   (rs_val),
        .b_i   (rt_val),
        .eq_o  (eq_flag),
        .neg_o (neg_flag)
    );

    npc_targets #(.W(W), .JW(JW), .IW(IW)) u_tgt (
        .pc_i  (pc_q),
        .jf_i  (jfield),
        .imm_i (imm),
        .seq_o (seq_t),
        .jmp_o (jmp_t),
        .br_o  (br_t)
    );

    npc_select #(.W(W)) u_sel (
        .cls_i (cls_e),
        .eq_i  (eq_flag),
        .neg_i (neg_flag),
        .seq_i (seq_t),
        .jmp_i (jmp_t),
        .br_i  (br_t),
        .reg_i (rs_val),
        .nxt_o (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)        pc_q <= '0;
        else if (ld_pc) pc_q <= nxt;
    end

    always_comb pc = pc_q;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int W  = 32,
    parameter int JW = 26,
    parameter int IW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          ld_pc,
    input logic [2:0]    cls,
    input logic [JW-1:0] jfield,
    input logic [IW-1:0] imm,
    input logic [W-1:0]  rs_val,
    input logic [W-1:0]  rt_val,
    input logic [W-1:0]  pc,
    input logic          eq_flag,
    input logic          neg_flag
);
    localparam int REGW = W - JW - 2;

    AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (pc == '0)); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ld_pc |=> $stable(pc)); // R2

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (ld_pc && cls == 3'd0) |=> (pc == $past(pc) + W'(4))); // R3

    AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
        (ld_pc && cls == 3'd1) |=>
        (pc == {$past(pc[W-1 -: REGW]), $past(jfield), 2'b00})); // R4

    AST_JREG_LOAD: assert property (@(posedge clk) disable iff (rst)
        (ld_pc && cls == 3'd2) |=> (pc == $past(rs_val))); // R5

    AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (ld_pc && cls == 3'd3 && rs_val == rt_val) |=>
        (pc == $past(pc) + {{(W-IW){$past(imm[IW-1])}}, $past(imm)})); // R6

    AST_BLTZ_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (ld_pc && cls == 3'd4 && rs_val[W-1]) |=>
        (pc == $past(pc) + {{(W-IW){$past(imm[IW-1])}}, $past(imm)})); // R7

    AST_EQ_FLAG: assert property (@(posedge clk) disable iff (rst)
        eq_flag == (rs_val == rt_val)); // R8

    AST_NEG_FLAG: assert property (@(posedge clk) disable iff (rst)
        neg_flag == rs_val[W-1]); // R9

    AST_RESERVED_SEQ: assert property (@(posedge clk) disable iff (rst)
        (ld_pc && cls > 3'd4) |=> (pc == $past(pc) + W'(4))); // R10
endmodule

bind npc_unit npc_unit_chk #(.W(W), .JW(JW), .IW(IW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ld_pc    (ld_pc),
    .cls      (cls),
    .jfield   (jfield),
    .imm      (imm),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .pc       (pc),
    .eq_flag  (eq_flag),
    .neg_flag (neg_flag)
);

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_pc = 1'b0;
    logic [2:0]  cls = 3'd0;
    logic [25:0] jfield = '0;
    logic [15:0] imm = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] pc;
    logic        eq_flag, neg_flag;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [31:0] model_pc;

    always #2.5 clk = ~clk;

    npc_unit u0 (
        .clk(clk), .rst(rst), .ld_pc(ld_pc), .cls(cls), .jfield(jfield),
        .imm(imm), .rs_val(rs_val), .rt_val(rt_val), .pc(pc),
        .eq_flag(eq_flag), .neg_flag(neg_flag)
    );

    // entry: {cls, imm, jfield, rs, rt, exp_eq, exp_neg}
    localparam int NV = 14;
    localparam logic [110:0] VEC [0:NV-1] = '{
        {3'd2, 16'h0000, 26'h0,       32'h0000_1000, 32'h0000_0000, 1'b0, 1'b0}, // R5
        {3'd0, 16'h0000, 26'h0,       32'h0000_0003, 32'h0000_0004, 1'b0, 1'b0}, // R3
        {3'd3, 16'h0010, 26'h0,       32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1, 1'b1}, // R6 taken
        {3'd3, 16'h0100, 26'h0,       32'h0000_0005, 32'h0000_0006, 1'b0, 1'b0}, // R6 not taken
        {3'd3, 16'h0040, 26'h0,       32'h0001_0005, 32'h0000_0005, 1'b0, 1'b0}, // R8 high bits
        {3'd4, 16'hFFF0, 26'h0,       32'h8000_0000, 32'h8000_0001, 1'b0, 1'b1}, // R7 taken
        {3'd4, 16'hFFF0, 26'h0,       32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0}, // R7 not taken
        {3'd2, 16'h0000, 26'h0,       32'hA000_0010, 32'h0000_0000, 1'b0, 1'b1}, // R5
        {3'd1, 16'h1234, 26'h0123456, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0}, // R4
        {3'd5, 16'h0000, 26'h3FFFFFF, 32'h9000_0000, 32'h9000_0000, 1'b1, 1'b1}, // R10
        {3'd7, 16'h8000, 26'h0,       32'h9000_0000, 32'h9000_0000, 1'b1, 1'b1}, // R10
        {3'd2, 16'h0000, 26'h0,       32'hFFFF_FFFC, 32'h0000_0001, 1'b0, 1'b1}, // R5
        {3'd0, 16'h0000, 26'h0,       32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0}, // R11 wrap
        {3'd3, 16'h8000, 26'h0,       32'h0000_0042, 32'h0000_0042, 1'b1, 1'b0}  // R11 negative
    };

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] ref_next(input logic [31:0] p, input logic [2:0] c,
                                             input logic [15:0] im, input logic [25:0] jf,
                                             input logic [31:0] a, input logic [31:0] b);
        case (c)
            3'd1: return {p[31:28], jf, 2'b00};
            3'd2: return a;
            3'd3: return (a == b) ? p + sx(im) : p + 32'd4;
            3'd4: return a[31] ? p + sx(im) : p + 32'd4;
            default: return p + 32'd4;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", pc, 32'h0);
        rst = 1'b0;
        model_pc = 32'h0;

        for (int i = 0; i < NV; i++) begin
            logic [2:0]  c;
            logic [15:0] im;
            logic [25:0] jf;
            logic [31:0] a, b;
            logic        e_eq, e_neg;
            {c, im, jf, a, b, e_eq, e_neg} = VEC[i];
            cls = c; imm = im; jfield = jf; rs_val = a; rt_val = b; ld_pc = 1'b1;
            #0.5;
            check("R8 eq_flag", {31'b0, eq_flag}, {31'b0, e_eq});
            check("R9 neg_flag", {31'b0, neg_flag}, {31'b0, e_neg});
            model_pc = ref_next(model_pc, c, im, jf, a, b);
            @(negedge clk);
            check($sformatf("R3-R7/R10/R11 vector %0d", i), pc, model_pc);
        end

        // R2: ld_pc low, jump class offered, counter must hold
        ld_pc = 1'b0; cls = 3'd1; jfield = 26'h2AAAAAA; rs_val = 32'h1234_5678;
        repeat (3) @(negedge clk);
        check("R2 hold", pc, model_pc);
        cls = 3'd2;
        @(negedge clk);
        check("R2 hold jreg", pc, model_pc);

        // R1: reset beats load strobe
        ld_pc = 1'b1; cls = 3'd2; rs_val = 32'h5555_0000; rst = 1'b1;
        @(negedge clk);
        check("R1 reset over load", pc, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R5 after reset", pc, 32'h5555_0000);

        // R4: region bits kept from nonzero counter
        cls = 3'd1; jfield = 26'h3FFFFFF;
        @(negedge clk);
        check("R4 region", pc, 32'h5FFF_FFFC);
        ld_pc = 1'b0;

        done = 1'b1;
        summary();
    end
endmodule